// File: doc/BRIEF.md
# Storage Port Interrupt Status Logic

This block holds, for each port of a two-port serial storage host controller, an interrupt status register and an interrupt enable register. Strobes from the receive path report that a frame of a given kind has been written to memory, or that a PIO data phase has finished. Each strobe sets a status bit. Software reads both registers over a simple register bus and clears status bits by writing ones. One status bit, the unknown-frame bit, cannot be cleared by writing it. It clears only when the diagnostic bit for unknown frames in the port's error register is cleared. That error register lives outside this block and signals the clear with a strobe.

Each port drives one level interrupt line. The line is high when at least one status bit and its enable bit are both set and the global interrupt enable is high. Status bits still record events while their enable bits are low. The register bus is single-cycle with a 9-bit byte address. Writes take effect at the clock edge that samples them. Read data is registered and appears one clock after the address is presented.

Top module: `stor_port_irq`

## Requirements
- R1: After reset, all four registers read 00000000h and both interrupt lines are low.
- R2: Port p's status register is at byte address 110h + p*80h and its enable register is 4 bytes above it, so port 0 uses 110h/114h and port 1 uses 190h/194h. Any other address reads 0. Read data appears on the clock after the address is sampled and holds the register value from before that edge.
- R3: Status bit 0 (device-to-host register frame), bit 2 (DMA setup frame) and bit 3 (set-device-bits frame) are set by their stored strobe only when the frame interrupt flag is 1 in the same cycle. With the flag at 0 the strobe changes nothing.
- R4: Status bit 1 (PIO setup) is set by the PIO data-phase-done strobe together with the frame interrupt flag. The receive path issues that strobe for an errored transfer as well as for a clean one.
- R5: Writing 1 to any of status bits 3..0 clears that bit. Writing 0 leaves it unchanged.
- R6: Status bit 4 (unknown frame posted to memory) is set by its strobe, with no interrupt flag needed. Software writes never clear it. Only the diagnostic-clear strobe clears it.
- R7: If a set strobe and a clear (write-one or diagnostic-clear) reach the same bit in the same cycle, the bit ends up set.
- R8: In the enable register, bits 30, 29 and 4..0 are read/write. Bit 31 and every other bit always read 0, and writes to them are ignored.
- R9: A port's interrupt line is high in the cycle after some status bit and its matching enable bit are both 1 while the global enable is 1, and low in the cycle after that stops being true. A status bit still sets while its enable is 0, without raising the line.
- R10: The two ports are independent. Register writes and event strobes for one port never change the other port's registers or interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gie | input | 1 | Global interrupt enable |
| d2h_stored | input | NUM_PORTS | Device-to-host register frame stored, per port |
| pio_done | input | NUM_PORTS | PIO setup frame stored and its data phase finished, per port |
| dma_stored | input | NUM_PORTS | DMA setup frame stored, per port |
| sdb_stored | input | NUM_PORTS | Set-device-bits frame stored, per port |
| frame_iflag | input | NUM_PORTS | Interrupt flag of the frame reported this cycle, per port |
| unk_posted | input | NUM_PORTS | Unknown frame posted to memory, per port |
| diag_f_clr | input | NUM_PORTS | Software cleared the unknown-frame diagnostic bit, per port |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Write enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | NUM_PORTS | Level interrupt line, per port |

## Verification
The bench builds the block with its default parameters: two ports, a 9-bit address and 32-bit data. With these values the upper port's registers sit at 190h/194h, near the top of the address space, and the unmapped addresses in between can be exercised. Two ports are enough to show that one port's traffic leaves the other alone. The 32-bit width brings the read-only bit 31 and the other unwritable enable bits within reach of write-all-ones patterns. A long random phase then mixes strobes, flags, diagnostic clears, writes and changes of the global enable against the behavioural model. This produces same-cycle set-versus-clear collisions on every bit.

// File: rtl/stor_irq_pkg.sv
// Package: constants shared by the storage port interrupt logic.
// Assumes 32-bit registers; the address map is derived from the base,
// the per-port stride and the offset of the enable register.
package stor_irq_pkg;
    localparam int unsigned REG_W       = 32;
    localparam int unsigned STS_W       = 5;
    localparam int unsigned STS_BASE    = 32'h110;
    localparam int unsigned EN_OFS      = 32'h4;
    localparam int unsigned PORT_STRIDE = 32'h80;
    localparam logic [REG_W-1:0] EN_RW_MASK = 32'h6000_001F;

    // status bit positions (software decodes these)
    localparam int unsigned BIT_D2H = 0;
    localparam int unsigned BIT_PIO = 1;
    localparam int unsigned BIT_DMA = 2;
    localparam int unsigned BIT_SDB = 3;
    localparam int unsigned BIT_UNK = 4;
    localparam int unsigned W1C_W   = 4;   // bits below BIT_UNK are write-one-to-clear
endpackage

// File: rtl/stor_irq_port_regs.sv
// Module: status/enable register pair and interrupt line for one port.
// Assumes event strobes are single-cycle and already aligned to clk.
// Set events win over same-cycle clears. The interrupt is registered.
module stor_irq_port_regs
    import stor_irq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 9,
    parameter int unsigned DATA_W   = REG_W,
    parameter int unsigned STS_ADDR = STS_BASE,
    parameter int unsigned EN_ADDR  = STS_BASE + EN_OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gie,
    input  logic              d2h_stored,
    input  logic              pio_done,
    input  logic              dma_stored,
    input  logic              sdb_stored,
    input  logic              frame_iflag,
    input  logic              unk_posted,
    input  logic              diag_f_clr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [STS_W-1:0]  sts_q,
    output logic [DATA_W-1:0] en_q,
    output logic              irq_q
);
    localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(EN_RW_MASK);

    logic             wr_sts, wr_en;
    logic [STS_W-1:0] set_vec, clr_vec, sts_d;

    // Purpose: decode register writes aimed at this port.
    always_comb begin
        wr_sts = reg_wr && (reg_addr == ADDR_W'(STS_ADDR));
        wr_en  = reg_wr && (reg_addr == ADDR_W'(EN_ADDR));
    end

    // Purpose: gather set and clear requests and form the next status value.
    always_comb begin
        set_vec          = '0;
        set_vec[BIT_D2H] = d2h_stored & frame_iflag;
        set_vec[BIT_PIO] = pio_done   & frame_iflag;
        set_vec[BIT_DMA] = dma_stored & frame_iflag;
        set_vec[BIT_SDB] = sdb_stored & frame_iflag;
        set_vec[BIT_UNK] = unk_posted;
        clr_vec          = '0;
        clr_vec[W1C_W-1:0] = wr_sts ? reg_wdata[W1C_W-1:0] : '0;
        clr_vec[BIT_UNK] = diag_f_clr;
        sts_d = (sts_q & ~clr_vec) | set_vec;
    end

    // Purpose: status register.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    // Purpose: enable register, only writable bits stored.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= reg_wdata & EN_MASK;
    end

    // Purpose: registered level interrupt for this port.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= gie && ((sts_q & en_q[STS_W-1:0]) != '0);
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

    // R5
    w1c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sts |=> ((sts_q[W1C_W-1:0] & $past(sts_q[W1C_W-1:0])) == $past(sts_q[W1C_W-1:0])));

    // R6
    unk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[BIT_UNK] && !diag_f_clr) |=> sts_q[BIT_UNK]);

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_iflag && !unk_posted) |=> ((sts_q & ~$past(sts_q)) == '0));

    // R9
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |=> !irq_q);
endmodule

// File: rtl/stor_irq_rdmux.sv
// Module: read-data selection for all ports' registers.
// Assumes the port windows do not overlap. Unmapped addresses read 0.
// Data is registered, so it appears one clock after the address.
module stor_irq_rdmux
    import stor_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned DATA_W    = REG_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [NUM_PORTS*STS_W-1:0]    sts_all,
    input  logic [NUM_PORTS*DATA_W-1:0]   en_all,
    output logic [DATA_W-1:0]             rdata_q
);
    logic [DATA_W-1:0] rd_d;

    // Purpose: pick the addressed register, zero when nothing matches.
    always_comb begin
        rd_d = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (reg_addr == ADDR_W'(STS_BASE + p * PORT_STRIDE))
                rd_d = DATA_W'(sts_all[p*STS_W +: STS_W]);
            if (reg_addr == ADDR_W'(STS_BASE + p * PORT_STRIDE + EN_OFS))
                rd_d = en_all[p*DATA_W +: DATA_W];
        end
    end

    // Purpose: read data register.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rd_d;
    end

    // R1
    rd_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (rdata_q == '0));
endmodule

// File: rtl/stor_port_irq.sv
// Module: top of the storage port interrupt status logic.
// One register pair and interrupt line per port, plus a shared read mux.
// Assumes the port address windows fit within ADDR_W.
module stor_port_irq
    import stor_irq_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned ADDR_W    = 9,
    parameter int unsigned DATA_W    = REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 gie,
    input  logic [NUM_PORTS-1:0] d2h_stored,
    input  logic [NUM_PORTS-1:0] pio_done,
    input  logic [NUM_PORTS-1:0] dma_stored,
    input  logic [NUM_PORTS-1:0] sdb_stored,
    input  logic [NUM_PORTS-1:0] frame_iflag,
    input  logic [NUM_PORTS-1:0] unk_posted,
    input  logic [NUM_PORTS-1:0] diag_f_clr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic [NUM_PORTS-1:0] irq
);
    logic [NUM_PORTS*STS_W-1:0]  sts_all;
    logic [NUM_PORTS*DATA_W-1:0] en_all;

    // Purpose: one register pair per port at its own address window.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        stor_irq_port_regs #(
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .STS_ADDR (STS_BASE + p * PORT_STRIDE),
            .EN_ADDR  (STS_BASE + p * PORT_STRIDE + EN_OFS)
        ) i_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .gie         (gie),
            .d2h_stored  (d2h_stored[p]),
            .pio_done    (pio_done[p]),
            .dma_stored  (dma_stored[p]),
            .sdb_stored  (sdb_stored[p]),
            .frame_iflag (frame_iflag[p]),
            .unk_posted  (unk_posted[p]),
            .diag_f_clr  (diag_f_clr[p]),
            .reg_addr    (reg_addr),
            .reg_wr      (reg_wr),
            .reg_wdata   (reg_wdata),
            .sts_q       (sts_all[p*STS_W +: STS_W]),
            .en_q        (en_all[p*DATA_W +: DATA_W]),
            .irq_q       (irq[p])
        );
    end

    stor_irq_rdmux #(
        .NUM_PORTS (NUM_PORTS),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) i_rdmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_addr (reg_addr),
        .sts_all  (sts_all),
        .en_all   (en_all),
        .rdata_q  (reg_rdata)
    );
endmodule

// File: tb/test_stor_port_irq.sv
`timescale 1ns/1ps
module test_stor_port_irq;
    localparam logic [8:0] A_S0 = 9'h110, A_E0 = 9'h114, A_S1 = 9'h190, A_E1 = 9'h194;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gie = 1'b0;
    logic [1:0] d2h_stored = '0, pio_done = '0, dma_stored = '0, sdb_stored = '0;
    logic [1:0] frame_iflag = '0, unk_posted = '0, diag_f_clr = '0;
    logic [8:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  irq;

    always #10 clk = ~clk;   // 50 MHz

    stor_port_irq i_stor_port_irq (
        .clk(clk), .rst_n(rst_n), .gie(gie),
        .d2h_stored(d2h_stored), .pio_done(pio_done), .dma_stored(dma_stored),
        .sdb_stored(sdb_stored), .frame_iflag(frame_iflag), .unk_posted(unk_posted),
        .diag_f_clr(diag_f_clr), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    bit cmp_on = 0, done = 0;
    string cur_req = "R1";

    // behavioural reference model
    logic [31:0] m_sts [2];
    logic [31:0] m_en  [2];
    logic [31:0] e_rdata;
    logic [1:0]  e_irq;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < 2; p++) begin m_sts[p] = 0; m_en[p] = 0; end
            e_rdata = 0; e_irq = 0;
        end else begin
            e_rdata = 0;
            for (int p = 0; p < 2; p++) begin
                if (reg_addr == 9'h110 + 9'(p * 128)) e_rdata = m_sts[p];
                if (reg_addr == 9'h114 + 9'(p * 128)) e_rdata = m_en[p];
                e_irq[p] = gie && ((m_sts[p] & m_en[p]) != 0);
            end
            for (int p = 0; p < 2; p++) begin
                logic [31:0] s, c;
                s = 0; c = 0;
                if (frame_iflag[p]) begin
                    if (d2h_stored[p]) s |= 32'h1;
                    if (pio_done[p])   s |= 32'h2;
                    if (dma_stored[p]) s |= 32'h4;
                    if (sdb_stored[p]) s |= 32'h8;
                end
                if (unk_posted[p]) s |= 32'h10;
                if (reg_wr && reg_addr == 9'h110 + 9'(p * 128)) c |= reg_wdata & 32'hF;
                if (diag_f_clr[p]) c |= 32'h10;
                m_sts[p] = (m_sts[p] & ~c) | s;
                if (reg_wr && reg_addr == 9'h114 + 9'(p * 128)) m_en[p] = reg_wdata & 32'h6000_001F;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(reg_rdata, e_rdata, cur_req, "model rdata");
            chk({31'd0, irq[0]}, {31'd0, e_irq[0]}, cur_req, "model irq0");
            chk({31'd0, irq[1]}, {31'd0, e_irq[1]}, cur_req, "model irq1");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1;
            n_err++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic idle();
        d2h_stored = '0; pio_done = '0; dma_stored = '0; sdb_stored = '0;
        frame_iflag = '0; unk_posted = '0; diag_f_clr = '0;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    // one cycle of stimulus; kinds: bit0 d2h, bit1 pio, bit2 dma, bit3 sdb, bit4 unknown
    task automatic drive(input int p, input logic [4:0] kinds, input logic fl, input logic dclr,
                         input logic wr, input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        idle();
        d2h_stored[p] = kinds[0]; pio_done[p] = kinds[1]; dma_stored[p] = kinds[2];
        sdb_stored[p] = kinds[3]; unk_posted[p] = kinds[4];
        frame_iflag[p] = fl; diag_f_clr[p] = dclr;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
    endtask

    task automatic wr_reg(input logic [8:0] a, input logic [31:0] d);
        drive(0, 5'b0, 1'b0, 1'b0, 1'b1, a, d);
    endtask

    task automatic read_chk(input logic [8:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); idle(); reg_addr = a;
        @(negedge clk); chk(reg_rdata, exp, req, "read");
    endtask

    task automatic irq_chk(input int p, input logic exp, input string req);
        @(negedge clk); idle();
        @(negedge clk); chk({31'd0, irq[p]}, {31'd0, exp}, req, "irq line");
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        // R1 reset state
        cur_req = "R1";
        read_chk(A_S0, 0, "R1"); read_chk(A_E0, 0, "R1");
        read_chk(A_S1, 0, "R1"); read_chk(A_E1, 0, "R1");
        chk({30'd0, irq}, 0, "R1", "irq after reset");
        // R8 enable writable bits
        cur_req = "R8";
        wr_reg(A_E0, 32'hFFFF_FFFF); read_chk(A_E0, 32'h6000_001F, "R8");
        wr_reg(A_E0, 32'h9FFF_FFE0); read_chk(A_E0, 32'h0, "R8");
        // R3 flag qualification and frame kinds
        cur_req = "R3";
        drive(0, 5'b00001, 1'b0, 1'b0, 1'b0, A_S0, 0); read_chk(A_S0, 32'h0, "R3");
        drive(0, 5'b00001, 1'b1, 1'b0, 1'b0, A_S0, 0); read_chk(A_S0, 32'h1, "R3");
        drive(0, 5'b00100, 1'b1, 1'b0, 1'b0, A_S0, 0); read_chk(A_S0, 32'h5, "R3");
        drive(0, 5'b01000, 1'b1, 1'b0, 1'b0, A_S0, 0); read_chk(A_S0, 32'hD, "R3");
        // R4 PIO data phase done
        cur_req = "R4";
        drive(0, 5'b00010, 1'b1, 1'b0, 1'b0, A_S0, 0); read_chk(A_S0, 32'hF, "R4");
        // R6 unknown frame bit, R5 write-one-to-clear
        cur_req = "R6";
        drive(0, 5'b10000, 1'b0, 1'b0, 1'b0, A_S0, 0); read_chk(A_S0, 32'h1F, "R6");
        cur_req = "R5";
        wr_reg(A_S0, 32'h0);  read_chk(A_S0, 32'h1F, "R5");
        wr_reg(A_S0, 32'h5);  read_chk(A_S0, 32'h1A, "R5");
        wr_reg(A_S0, 32'hFFFF_FFFF); read_chk(A_S0, 32'h10, "R6");
        cur_req = "R6";
        drive(0, 5'b0, 1'b0, 1'b1, 1'b0, A_S0, 0); read_chk(A_S0, 32'h0, "R6");
        // R7 set beats clear
        cur_req = "R7";
        drive(0, 5'b00001, 1'b1, 1'b0, 1'b1, A_S0, 32'h1); read_chk(A_S0, 32'h1, "R7");
        drive(0, 5'b10000, 1'b0, 1'b1, 1'b0, A_S0, 0);     read_chk(A_S0, 32'h11, "R7");
        // R9 interrupt generation
        cur_req = "R9";
        gie = 1'b1;
        irq_chk(0, 1'b0, "R9");
        wr_reg(A_E0, 32'h1); irq_chk(0, 1'b1, "R9");
        @(negedge clk); gie = 1'b0; irq_chk(0, 1'b0, "R9");
        @(negedge clk); gie = 1'b1; irq_chk(0, 1'b1, "R9");
        wr_reg(A_S0, 32'h1); irq_chk(0, 1'b0, "R9");
        read_chk(A_S0, 32'h10, "R9");
        // R10 port independence
        cur_req = "R10";
        drive(1, 5'b01000, 1'b1, 1'b0, 1'b0, A_S0, 0);
        read_chk(A_S1, 32'h8, "R10"); read_chk(A_S0, 32'h10, "R10");
        wr_reg(A_E1, 32'h8); irq_chk(1, 1'b1, "R10");
        chk({31'd0, irq[0]}, 0, "R10", "port0 irq untouched");
        // R2 unmapped addresses
        cur_req = "R2";
        read_chk(9'h118, 0, "R2"); read_chk(9'h111, 0, "R2"); read_chk(9'h010, 0, "R2");
        // random mix against the model
        cur_req = "R9 random";
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            idle();
            gie = ($urandom % 10) != 0;
            for (int p = 0; p < 2; p++) begin
                d2h_stored[p] = ($urandom % 6) == 0; pio_done[p]   = ($urandom % 6) == 0;
                dma_stored[p] = ($urandom % 6) == 0; sdb_stored[p] = ($urandom % 6) == 0;
                unk_posted[p] = ($urandom % 8) == 0; diag_f_clr[p] = ($urandom % 8) == 0;
                frame_iflag[p] = ($urandom % 3) != 0;
            end
            case ($urandom % 6)
                0: reg_addr = A_S0;
                1: reg_addr = A_E0;
                2: reg_addr = A_S1;
                3: reg_addr = A_E1;
                4: reg_addr = 9'($urandom);
                default: reg_addr = 9'h118;
            endcase
            reg_wr = ($urandom % 3) == 0;
            reg_wdata = $urandom;
        end
        @(negedge clk); idle();
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule